// File: doc/BRIEF.md
# Soft Mute Gain Ramp

This block sits at the output of an audio sample-rate path. It multiplies each outgoing stereo sample pair by a gain that moves one step per output frame, from unity down to silence or back. The ramp is driven by a mute request. The ramp can turn around at any level: dropping the request part way through a fade-out sends the gain back up from the level it has reached. Both channels share the gain value, so the left/right balance is kept at every point of the fade.

A mode select picks manual or semi-automatic behaviour. In manual mode, only the mute request moves the gain. In semi-automatic mode, the block keeps the output silent for a fixed number of frames after power-down is released, and then fades in by itself. If the mute request is high when that hold ends, the output stays silent. While power-down is asserted, both outputs are zero.

The gain counts from 0 to 1024. The output is the signed sample times the gain, shifted arithmetically right by 10. The result is exact silence at 0 and an exact copy of the input at 1024.

Top module: `smute_ctrl`

## Requirements
- R1: With mute requested, each frame strobe lowers the gain by one step; starting from unity, the output reaches zero after exactly 1024 strobes and stays there.
- R2: With mute not requested (and no hold active), each frame strobe raises the gain by one step; starting from zero, the output equals the input after exactly 1024 strobes and stays there.
- R3: Removing the mute request part way through a fade-out makes the gain rise again from the level it reached, one step per strobe, with no jump.
- R4: The gain changes only on a cycle with frame_stb high, and by at most one step.
- R5: Each output equals the signed 24-bit input times the gain, arithmetic-shifted right by 10 bits (floor toward minus infinity), and the same gain is applied to both channels.
- R6: muted is high whenever the gain is zero (including right after rst_n), and the outputs are then zero.
- R7: While pwr_dn is high, out_l and out_r are zero and muted is high.
- R8: In manual mode (semi_auto = 0), power-down presets the gain to unity, so after release the input passes through unchanged with no fade-in.
- R9: In semi-automatic mode (semi_auto = 1), power-down presets the gain to zero; after release, the output stays zero for 4410 frame strobes, and the gain first rises on strobe 4411.
- R10: In semi-automatic mode, if mute_req is high when the 4410-strobe hold ends, the output stays muted; the fade-in starts on the first strobe after mute_req goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; gain starts at zero |
| frame_stb | input | 1 | One-cycle pulse per output frame; advances the ramp |
| mute_req | input | 1 | Mute request; high fades out, low fades in |
| pwr_dn | input | 1 | Power-down; forces zero output and presets the ramp |
| semi_auto | input | 1 | 0 = manual mode, 1 = semi-automatic post-power-down hold |
| in_l | input | 24 | Left input sample, two's complement |
| in_r | input | 24 | Right input sample, two's complement |
| out_l | output | 24 | Left attenuated sample |
| out_r | output | 24 | Right attenuated sample |
| muted | output | 1 | High when gain is zero or power-down is active |

## Verification
The checker assumes that semi_auto changes only while pwr_dn is high. It also assumes that frame_stb is a single-cycle pulse, so that one frame causes one ramp step. The bench drives every input on the falling clock edge. It changes the mode only inside a power-down pulse, and it raises frame_stb for exactly one cycle per frame with at least one idle cycle between strobes. The step and freeze properties read the internal gain register, so they do not depend on any particular sample values.

// File: rtl/smute_pkg.sv
package smute_pkg;

  localparam int NUM_CH = 2;

  typedef enum logic {
    MODE_MANUAL = 1'b0,
    MODE_SEMI   = 1'b1
  } mode_e;

  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_DOWN = 2'd1,
    RAMP_UP   = 2'd2
  } ramp_dir_e;

endpackage

// File: rtl/smute_hold_timer.sv
module smute_hold_timer #(
  parameter int HOLD_FRAMES = 4410
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_dn,
  input  logic frame_stb,
  output logic hold_active
);

  localparam int HOLD_W = $clog2(HOLD_FRAMES + 1);
  localparam logic [HOLD_W-1:0] HOLD_LIMIT = HOLD_W'(HOLD_FRAMES);

  logic [HOLD_W-1:0] cnt_q;
  logic [HOLD_W-1:0] cnt_d;
  logic              cnt_en;

  assign hold_active = (cnt_q < HOLD_LIMIT);

  // restart on power-down, count strobes until the limit, then stick
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (pwr_dn) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (frame_stb && hold_active) begin
      cnt_d  = cnt_q + HOLD_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/smute_gain_ramp.sv
module smute_gain_ramp
  import smute_pkg::*;
#(
  parameter int RAMP_LOG2 = 10,
  localparam int GAIN_W   = RAMP_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_dn,
  input  logic              preset_unity,
  input  logic              frame_stb,
  input  logic              want_mute,
  output logic [GAIN_W-1:0] gain
);

  localparam logic [GAIN_W-1:0] GAIN_MAX = {1'b1, {RAMP_LOG2{1'b0}}};

  logic [GAIN_W-1:0] gain_q;
  logic [GAIN_W-1:0] gain_d;
  logic              gain_en;
  ramp_dir_e         dir;

  assign gain = gain_q;

  // direction with saturation at both ends
  always_comb begin
    if (want_mute) begin
      dir = (gain_q == '0) ? RAMP_HOLD : RAMP_DOWN;
    end else begin
      dir = (gain_q == GAIN_MAX) ? RAMP_HOLD : RAMP_UP;
    end
  end

  always_comb begin
    gain_d  = gain_q;
    gain_en = pwr_dn | frame_stb;
    if (pwr_dn) begin
      gain_d = preset_unity ? GAIN_MAX : '0;
    end else begin
      case (dir)
        RAMP_DOWN: gain_d = gain_q - GAIN_W'(1);
        RAMP_UP:   gain_d = gain_q + GAIN_W'(1);
        default:   gain_d = gain_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= '0;
    end else if (gain_en) begin
      gain_q <= gain_d;
    end
  end

endmodule

// File: rtl/smute_scaler.sv
module smute_scaler #(
  parameter int SAMPLE_W = 24,
  parameter int GAIN_W   = 11,
  parameter int SHIFT    = 10
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [GAIN_W-1:0]   gain,
  input  logic                force_zero,
  output logic [SAMPLE_W-1:0] scaled
);

  localparam int PROD_W = SAMPLE_W + GAIN_W + 1;

  logic signed [PROD_W-1:0] prod;

  // gain is unsigned; a zero sign bit keeps the multiply signed
  assign prod   = PROD_W'($signed(sample) * $signed({1'b0, gain}));
  assign scaled = force_zero ? '0 : SAMPLE_W'(prod >>> SHIFT);

endmodule

// File: rtl/smute_ctrl.sv
module smute_ctrl
  import smute_pkg::*;
#(
  parameter int SAMPLE_W    = 24,
  parameter int RAMP_LOG2   = 10,
  parameter int HOLD_FRAMES = 4410
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_stb,
  input  logic                mute_req,
  input  logic                pwr_dn,
  input  logic                semi_auto,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r,
  output logic                muted
);

  localparam int GAIN_W = RAMP_LOG2 + 1;

  mode_e             mode;
  logic              hold_active;
  logic              want_mute;
  logic [GAIN_W-1:0] gain_q;
  logic [SAMPLE_W-1:0] ch_in  [NUM_CH];
  logic [SAMPLE_W-1:0] ch_out [NUM_CH];

  assign mode      = semi_auto ? MODE_SEMI : MODE_MANUAL;
  assign want_mute = mute_req | ((mode == MODE_SEMI) & hold_active);

  smute_hold_timer #(
    .HOLD_FRAMES(HOLD_FRAMES)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .frame_stb  (frame_stb),
    .hold_active(hold_active)
  );

  smute_gain_ramp #(
    .RAMP_LOG2(RAMP_LOG2)
  ) u_ramp (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_dn      (pwr_dn),
    .preset_unity(mode == MODE_MANUAL),
    .frame_stb   (frame_stb),
    .want_mute   (want_mute),
    .gain        (gain_q)
  );

  assign ch_in[0] = in_l;
  assign ch_in[1] = in_r;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    smute_scaler #(
      .SAMPLE_W(SAMPLE_W),
      .GAIN_W  (GAIN_W),
      .SHIFT   (RAMP_LOG2)
    ) u_scale (
      .sample    (ch_in[c]),
      .gain      (gain_q),
      .force_zero(pwr_dn),
      .scaled    (ch_out[c])
    );
  end

  assign out_l = ch_out[0];
  assign out_r = ch_out[1];
  assign muted = pwr_dn | (gain_q == '0);

endmodule

// File: rtl/smute_ctrl_chk.sv
module smute_ctrl_chk #(
  parameter int SAMPLE_W  = 24,
  parameter int RAMP_LOG2 = 10,
  localparam int GAIN_W   = RAMP_LOG2 + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_stb,
  input logic                pwr_dn,
  input logic                semi_auto,
  input logic                hold_active,
  input logic [GAIN_W-1:0]   gain,
  input logic [SAMPLE_W-1:0] out_l,
  input logic [SAMPLE_W-1:0] out_r,
  input logic                muted
);

  localparam logic [GAIN_W-1:0] GAIN_MAX = {1'b1, {RAMP_LOG2{1'b0}}};

  assert_gain_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && !pwr_dn) |=> $stable(gain));

  assert_gain_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_stb && !pwr_dn) |=>
      (gain == $past(gain) || gain == $past(gain) + GAIN_W'(1) ||
       gain + GAIN_W'(1) == $past(gain)));

  assert_gain_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    gain <= GAIN_MAX);

  assert_pd_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |-> (out_l == '0 && out_r == '0 && muted));

  assert_muted_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    muted |-> (out_l == '0 && out_r == '0));

  assert_pd_preset_manual_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && !semi_auto) |=> gain == GAIN_MAX);

  assert_pd_preset_semi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_dn && semi_auto) |=> gain == '0);

  assert_hold_no_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (semi_auto && hold_active && !pwr_dn) |=> gain <= $past(gain));

endmodule

bind smute_ctrl smute_ctrl_chk #(
  .SAMPLE_W (SAMPLE_W),
  .RAMP_LOG2(RAMP_LOG2)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_stb  (frame_stb),
  .pwr_dn     (pwr_dn),
  .semi_auto  (semi_auto),
  .hold_active(hold_active),
  .gain       (gain_q),
  .out_l      (out_l),
  .out_r      (out_r),
  .muted      (muted)
);

// File: tb/tb_smute_ctrl.sv
module tb_smute_ctrl;

  localparam int SW = 24;
  localparam int NV = 8;

  logic          clk;
  logic          rst_n;
  logic          frame_stb;
  logic          mute_req;
  logic          pwr_dn;
  logic          semi_auto;
  logic [SW-1:0] in_l;
  logic [SW-1:0] in_r;
  logic [SW-1:0] out_l;
  logic [SW-1:0] out_r;
  logic          muted;

  int checks;
  int errors;

  smute_ctrl dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_stb(frame_stb),
    .mute_req (mute_req),
    .pwr_dn   (pwr_dn),
    .semi_auto(semi_auto),
    .in_l     (in_l),
    .in_r     (in_r),
    .out_l    (out_l),
    .out_r    (out_r),
    .muted    (muted)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // fields: strobes of fade-out from unity, left sample, right sample
  localparam logic [58:0] VECS [NV] = '{
    {11'd0,    24'h123456, 24'hEDCBA9},
    {11'd1,    24'h7FFFFF, 24'h800000},
    {11'd512,  24'h7FFFFF, 24'h800000},
    {11'd512,  24'hFFFFFF, 24'h000001},
    {11'd300,  24'h0ABCDE, 24'hF54321},
    {11'd1000, 24'h400000, 24'hC00000},
    {11'd1023, 24'h7FFFFF, 24'h800000},
    {11'd1024, 24'h7FFFFF, 24'h800000}
  };

  function automatic logic [SW-1:0] expect_out(input logic [SW-1:0] s, input int g);
    logic signed [47:0] p;
    p = 48'($signed(s)) * 48'(g);
    return SW'(p >>> 10);
  endfunction

  task automatic check(input string req, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobes(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk) frame_stb = 1'b1;
      @(negedge clk) frame_stb = 1'b0;
    end
  endtask

  task automatic pd_pulse(input logic semi);
    @(negedge clk);
    semi_auto = semi;
    pwr_dn    = 1'b1;
    @(negedge clk);
    @(negedge clk) pwr_dn = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    frame_stb = 1'b0;
    mute_req  = 1'b0;
    pwr_dn    = 1'b0;
    semi_auto = 1'b0;
    in_l      = 24'h2468AC;
    in_r      = 24'hDCBA98;
    repeat (3) @(negedge clk);
    // R6: gain is zero out of reset
    check("R6 reset muted", SW'(muted), SW'(1));
    check("R6 reset out_l", out_l, '0);
    @(negedge clk) rst_n = 1'b1;

    // table walk: R5 and R1, fade-out to a given depth then compare
    for (int i = 0; i < NV; i++) begin
      pd_pulse(1'b0);
      in_l     = VECS[i][47:24];
      in_r     = VECS[i][23:0];
      mute_req = 1'b1;
      strobes(int'(VECS[i][58:48]));
      mute_req = 1'b0;
      @(negedge clk);
      check("R5 table out_l", out_l, expect_out(VECS[i][47:24], 1024 - int'(VECS[i][58:48])));
      check("R5 table out_r", out_r, expect_out(VECS[i][23:0], 1024 - int'(VECS[i][58:48])));
    end

    // R7: power-down silences
    in_l = 24'h3FFFFF;
    in_r = 24'hC00001;
    @(negedge clk) pwr_dn = 1'b1;
    @(negedge clk);
    check("R7 pd out_l", out_l, '0);
    check("R7 pd out_r", out_r, '0);
    check("R7 pd muted", SW'(muted), SW'(1));
    @(negedge clk) pwr_dn = 1'b0;
    @(negedge clk);
    // R8: manual release passes through at once
    check("R8 manual unity", out_l, 24'h3FFFFF);
    check("R8 manual muted", SW'(muted), SW'(0));

    // R1: full fade-out timing
    mute_req = 1'b1;
    strobes(1023);
    check("R1 one step left muted", SW'(muted), SW'(0));
    check("R1 one step left out", out_l, expect_out(24'h3FFFFF, 1));
    strobes(1);
    check("R1 fully muted", SW'(muted), SW'(1));
    check("R1 zero out", out_r, '0);
    strobes(5);
    check("R1 stays at zero", out_l, '0);

    // R4: no strobe, no change
    mute_req = 1'b0;
    repeat (20) @(negedge clk);
    check("R4 frozen without strobe", SW'(muted), SW'(1));

    // R2: full fade-in timing
    strobes(1023);
    check("R2 one step short", out_l, expect_out(24'h3FFFFF, 1023));
    strobes(1);
    check("R2 unity reached", out_l, 24'h3FFFFF);
    strobes(3);
    check("R2 stays at unity", out_r, 24'hC00001);

    // R3: reversal mid fade
    mute_req = 1'b1;
    strobes(300);
    check("R3 partial depth", out_l, expect_out(24'h3FFFFF, 724));
    mute_req = 1'b0;
    strobes(100);
    check("R3 rising from reached level", out_l, expect_out(24'h3FFFFF, 824));
    strobes(200);
    check("R3 back to unity", out_l, 24'h3FFFFF);
    repeat (7) @(negedge clk);
    check("R4 idle at unity", out_r, 24'hC00001);

    // R9: semi-auto hold then automatic fade-in
    in_l = 24'h400000;
    in_r = 24'hC00000;
    pd_pulse(1'b1);
    @(negedge clk);
    check("R9 muted after release", SW'(muted), SW'(1));
    strobes(4410);
    check("R9 still silent at hold end", out_l, '0);
    check("R9 still muted at hold end", SW'(muted), SW'(1));
    strobes(1);
    check("R9 first rise out_l", out_l, 24'h001000);
    check("R9 first rise out_r", out_r, 24'hFFF000);
    strobes(1023);
    check("R9 unity after fade-in", out_l, 24'h400000);

    // R10: mute request held over the hold end
    mute_req = 1'b1;
    pd_pulse(1'b1);
    strobes(4460);
    check("R10 mute kept past hold", SW'(muted), SW'(1));
    check("R10 output silent past hold", out_r, '0);
    mute_req = 1'b0;
    @(negedge clk);
    check("R10 no change before strobe", SW'(muted), SW'(1));
    strobes(1);
    check("R10 fade-in starts", out_l, 24'h001000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule